// File: doc/BRIEF.md
# Radix-4 Booth Multiply-Accumulate Unit with Merged Carry-Save Accumulation

This block multiplies two signed 8-bit operands and adds the product into a running 16-bit total, one product per clock. The multiplier operand is recoded into four radix-4 Booth digits, each in {-2, -1, 0, +1, +2}, so only four partial-product rows are formed. Those rows, one constant/correction vector and the two halves of the running total enter a single chain of 3:2 carry-save compressors. The result is kept in redundant form as a sum vector and a carry vector, and it is fed back in that form. No adder resolves the total on the accumulate path.

A carry-propagate adder built from 2-bit carry-lookahead cells resolves the redundant pair only when a result is requested. The value appears one cycle after the request, together with a one-cycle valid pulse. When a row's Booth digit is zero, the selection and complement logic of that row keeps its previous output, so the bits feeding the adder array do not toggle needlessly. Only a single forcing gate at the array input substitutes the row's neutral value. A synchronous clear empties the total.

Top module: `mac_booth_r4`

## Requirements
- R1: After reset, res_valid is 0 and a read request returns an accumulated value of 0.
- R2: On a clock edge where op_valid is 1 and clear is 0, the total grows by op_a × op_b. Both operands are 8-bit two's complement, op_a is the multiplicand and op_b is the multiplier.
- R3: On an edge where op_valid and clear are both 0, the total is unchanged, whatever values op_a and op_b carry.
- R4: On an edge where clear is 1, the total becomes 0. An operand pair presented with op_valid in the same cycle is discarded.
- R5: A rd_req sampled at an edge makes res_valid 1 for exactly the following cycle. res_data then holds the total as it stood before that edge's own update, so an operation or clear in the same cycle is not yet included.
- R6: The total wraps modulo 2^16 and does not saturate.
- R7: The extreme products are exact: -128 × -128 adds +16384 (0x4000) and -128 × 127 adds -16256 (0xC080).
- R8: Multipliers whose Booth digits are partly or entirely zero accumulate correctly. A row whose digit is zero keeps its row output static while it is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Accumulate op_a × op_b at this edge |
| op_a | input | 8 | Multiplicand, two's complement |
| op_b | input | 8 | Multiplier, two's complement, Booth recoded |
| clear | input | 1 | Zero the running total; overrides op_valid |
| rd_req | input | 1 | Request the resolved total |
| res_valid | output | 1 | One-cycle pulse marking res_data valid |
| res_data | output | 16 | Resolved total, two's complement |

## Verification
The bench checks the products at the negative extremes. A wrong sign-handling constant or a missing one's-complement correction bit shows up there as an offset of a power of two. It runs multipliers with sparse or all-zero Booth digits while the multiplicand keeps changing, so a zero row that leaks its held value adds a stale multiple. Long runs that wrap past 2^16 expose a carry vector that loses its top bit or is shifted wrongly. The same-cycle cases (clear with an operation, read with an operation, read with clear) catch a design that reports the updated total, or lets an operation slip past a clear. A full sweep of all 65536 operand pairs closes out the recoding table.

// File: rtl/mac_pkg.sv
// Shared constants for the Booth multiply-accumulate unit.
// Assumes an even operand width so the multiplier splits into whole digit pairs.
package mac_pkg;
    localparam int MAC_DW = 8;             // operand width
    localparam int MAC_AW = 2 * MAC_DW;    // accumulator width
    localparam int MAC_NR = MAC_DW / 2;    // Booth rows
endpackage

// File: rtl/mac_booth_row.sv
// One radix-4 Booth partial-product row.
// Decodes a 3-bit multiplier window into a digit and forms the one's-complemented
// multiple of the multiplicand, with its sign bit inverted for constant-based sign
// handling. When the row is not updated (zero digit or no operation), the
// row output is the held copy, so the downstream array inputs do not toggle.
// Assumes the caller adds the neg bit at the row LSB and the sign constant.
module mac_booth_row #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mcand,
    input  logic [2:0]    grp,
    input  logic          drive,
    output logic [DW:0]   row_v,
    output logic          neg,
    output logic          live,
    output logic          upd
);
    localparam logic [DW:0] NEUTRAL = {1'b1, {DW{1'b0}}};

    logic          one_x;
    logic          two_x;
    logic [DW:0]   mag;
    logic [DW:0]   pp;
    logic [DW:0]   fresh;
    logic [DW:0]   held;

    // Digit decode: magnitude select and sign of the Booth digit.
    always_comb begin
        one_x = grp[1] ^ grp[0];
        two_x = (grp == 3'b011) || (grp == 3'b100);
        neg   = grp[2] & ~(grp[1] & grp[0]);
        live  = one_x | two_x;
        upd   = drive & live;
    end

    // Multiple selection and one's complement for negative digits.
    always_comb begin
        if (one_x)      mag = {mcand[DW-1], mcand};
        else if (two_x) mag = {mcand, 1'b0};
        else            mag = '0;
        pp    = mag ^ {(DW+1){neg}};
        fresh = {~pp[DW], pp[DW-1:0]};
        row_v = upd ? fresh : held;
    end

    // Hold register: only a non-zero digit on an accepted operation refreshes it.
    always_ff @(posedge clk) begin
        if (!rst_n)   held <= NEUTRAL;
        else if (upd) held <= fresh;
    end
endmodule

// File: rtl/mac_csa_merge.sv
// Linear chain of 3:2 carry-save compressors.
// Reduces NOPS vectors of width W to one sum and one carry vector using NOPS-2
// levels; carries are shifted left and the top carry is dropped (modulo 2^W).
module mac_csa_merge #(
    parameter int W    = 16,
    parameter int NOPS = 7
) (
    input  logic [NOPS-1:0][W-1:0] ops,
    output logic [W-1:0]           sum_o,
    output logic [W-1:0]           carry_o
);
    localparam int NLV = NOPS - 2;

    logic [NLV-1:0][W-1:0] s_l;
    logic [NLV-1:0][W-1:0] c_l;

    genvar k;
    generate
        for (k = 0; k < NLV; k++) begin : g_lvl
            logic [W-1:0] x;
            logic [W-1:0] y;
            logic [W-1:0] z;
            if (k == 0) begin : g_first
                assign x = ops[0];
                assign y = ops[1];
            end else begin : g_next
                assign x = s_l[k-1];
                assign y = c_l[k-1];
            end
            assign z = ops[k+2];
            // One compressor level: bitwise full adders.
            always_comb begin
                s_l[k] = x ^ y ^ z;
                c_l[k] = ((x & y) | (x & z) | (y & z)) << 1;
            end
        end
    endgenerate

    assign sum_o   = s_l[NLV-1];
    assign carry_o = c_l[NLV-1];
endmodule

// File: rtl/mac_cla2_chain.sv
// Carry-propagate adder made of 2-bit carry-lookahead cells.
// Each cell resolves two bits and its carry-out from generate/propagate terms
// and a carry input; cells are chained. W must be even. Result modulo 2^W.
module mac_cla2_chain #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    localparam int NC = W / 2;

    logic [NC:0] cc;
    assign cc[0] = 1'b0;

    genvar j;
    generate
        for (j = 0; j < NC; j++) begin : g_cell
            logic g0, p0, g1, p1, c1;
            // Two-bit lookahead: both carries from the cell carry-in directly.
            always_comb begin
                g0 = a[2*j]   & b[2*j];
                p0 = a[2*j]   ^ b[2*j];
                g1 = a[2*j+1] & b[2*j+1];
                p1 = a[2*j+1] ^ b[2*j+1];
                c1 = g0 | (p0 & cc[j]);
                s[2*j]   = p0 ^ cc[j];
                s[2*j+1] = p1 ^ c1;
                cc[j+1]  = g1 | (p1 & g0) | (p1 & p0 & cc[j]);
            end
        end
    endgenerate
endmodule

// File: rtl/mac_booth_r4.sv
// Signed multiply-accumulate with the running total merged into the
// partial-product compressor. Total kept as redundant sum/carry registers and
// resolved only on a read request. Clear overrides an operation in the same cycle;
// a read returns the total from before the edge at which it is sampled.
module mac_booth_r4 #(
    parameter int DW = mac_pkg::MAC_DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    input  logic            clear,
    input  logic            rd_req,
    output logic            res_valid,
    output logic [2*DW-1:0] res_data
);
    localparam int ACC_W = 2 * DW;
    localparam int NR    = DW / 2;
    localparam int NOPS  = NR + 3;
    localparam logic [DW:0] NEUTRAL = {1'b1, {DW{1'b0}}};

    // Sign-handling constant: removes the inverted-sign offset of every row.
    function automatic logic [ACC_W-1:0] sign_const();
        logic [ACC_W-1:0] k;
        k = '0;
        for (int i = 0; i < NR; i++) k = k - (ACC_W'(1) << (DW + 2*i));
        return k;
    endfunction
    localparam logic [ACC_W-1:0] SIGN_K = sign_const();

    logic [DW:0]               bext;
    logic                      drive;
    logic [NR-1:0][DW:0]       row_v;
    logic [NR-1:0]             row_neg;
    logic [NR-1:0]             row_live;
    logic [NR-1:0]             row_upd;
    logic [NOPS-1:0][ACC_W-1:0] ops;
    logic [ACC_W-1:0]          comp;
    logic [ACC_W-1:0]          sum_q, carry_q;
    logic [ACC_W-1:0]          sum_n, carry_n;
    logic [ACC_W-1:0]          resolved;

    assign bext  = {op_b, 1'b0};
    assign drive = op_valid & ~clear;

    genvar i;
    generate
        for (i = 0; i < NR; i++) begin : g_row
            mac_booth_row #(.DW(DW)) i_row (
                .clk   (clk),
                .rst_n (rst_n),
                .mcand (op_a),
                .grp   (bext[2*i+2 : 2*i]),
                .drive (drive),
                .row_v (row_v[i]),
                .neg   (row_neg[i]),
                .live  (row_live[i]),
                .upd   (row_upd[i])
            );
            // Array entry: a zero-digit row is forced to its neutral value.
            assign ops[i] = ACC_W'(row_live[i] ? row_v[i] : NEUTRAL) << (2*i);
        end
    endgenerate

    // Per-row two's-complement correction bits at each row LSB.
    always_comb begin
        comp = '0;
        for (int r = 0; r < NR; r++) comp[2*r] = row_neg[r] & row_live[r];
    end

    assign ops[NR]   = SIGN_K | comp;
    assign ops[NR+1] = sum_q;
    assign ops[NR+2] = carry_q;

    mac_csa_merge #(.W(ACC_W), .NOPS(NOPS)) i_csa (
        .ops     (ops),
        .sum_o   (sum_n),
        .carry_o (carry_n)
    );

    mac_cla2_chain #(.W(ACC_W)) i_cpa (
        .a (sum_q),
        .b (carry_q),
        .s (resolved)
    );

    // Redundant accumulator: clear wins, otherwise load on an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else if (op_valid) begin
            sum_q   <= sum_n;
            carry_q <= carry_n;
        end
    end

    // Read port: capture the resolved pre-update total and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= rd_req;
            if (rd_req) res_data <= resolved;
        end
    end
endmodule

// File: rtl/mac_booth_r4_chk.sv
// Property checker for mac_booth_r4, attached by bind below.
// Observes the redundant registers and the row outputs/update strobes.
module mac_booth_r4_chk #(
    parameter int W  = 16,
    parameter int NR = 4,
    parameter int RW = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic                clear,
    input logic                rd_req,
    input logic                res_valid,
    input logic [W-1:0]        sum_q,
    input logic [W-1:0]        carry_q,
    input logic [NR-1:0]       row_upd,
    input logic [NR-1:0][RW-1:0] row_v
);
    // R4: a clear leaves both redundant halves at zero.
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum_q == '0 && carry_q == '0));

    // R3: no operation and no clear keeps the total unchanged.
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !clear) |=> ($stable(sum_q) && $stable(carry_q)));

    // R5: a request yields a valid pulse on the next cycle.
    assert_read_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> res_valid);

    // R5: no request, no valid.
    assert_no_stray_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !res_valid);

    genvar i;
    generate
        for (i = 0; i < NR; i++) begin : g_hold
            // R8: a row not refreshed in two consecutive cycles stays static.
            assert_row_static_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!row_upd[i] && !$past(row_upd[i])) |-> $stable(row_v[i]));
        end
    endgenerate
endmodule

bind mac_booth_r4 mac_booth_r4_chk #(.W(ACC_W), .NR(NR), .RW(DW+1)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .clear     (clear),
    .rd_req    (rd_req),
    .res_valid (res_valid),
    .sum_q     (sum_q),
    .carry_q   (carry_q),
    .row_upd   (row_upd),
    .row_v     (row_v)
);

// File: tb/test_mac_booth_r4.sv
`timescale 1ns/1ps
// Directed bench for mac_booth_r4: one task per scenario, each checks itself.
module test_mac_booth_r4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic        clear = 1'b0;
    logic        rd_req = 1'b0;
    logic        res_valid;
    logic [15:0] res_data;

    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] model = '0;
    logic [15:0] prev_model = '0;

    always #4 clk = ~clk;

    mac_booth_r4 i_mac_booth_r4 (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_a (op_a),
        .op_b (op_b), .clear (clear), .rd_req (rd_req),
        .res_valid (res_valid), .res_data (res_data)
    );

    function automatic logic [15:0] prod(input logic [7:0] a, input logic [7:0] b);
        logic signed [15:0] p;
        p = $signed(a) * $signed(b);
        return p;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge and update the model.
    task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b,
                        input logic clr, input logic rd);
        @(negedge clk);
        op_valid = v; op_a = a; op_b = b; clear = clr; rd_req = rd;
        prev_model = model;
        if (clr)    model = '0;
        else if (v) model = model + prod(a, b);
    endtask

    task automatic read_check(input logic [15:0] exp, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
        check(res_valid === 1'b1, tag, {15'd0, res_valid}, 16'd1);
        check(res_data === exp, tag, res_data, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(res_valid === 1'b0, "R1 valid low", {15'd0, res_valid}, 16'd0);
        read_check(16'h0000, "R1 total zero");
    endtask

    task automatic t_corners;
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'h80, 8'h80, 1'b0, 1'b0);
        read_check(16'h4000, "R7 -128x-128");
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'h80, 8'h7F, 1'b0, 1'b0);
        read_check(16'hC080, "R7 -128x127");
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'h7F, 8'h80, 1'b0, 1'b0);
        read_check(16'hC080, "R7 127x-128");
    endtask

    task automatic t_zero_digits;
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'd100, 8'h00, 1'b0, 1'b0);
        step(1'b1, 8'hB3,  8'h00, 1'b0, 1'b0);
        step(1'b1, 8'd55,  8'h40, 1'b0, 1'b0);
        step(1'b1, 8'hDF,  8'h0C, 1'b0, 1'b0);
        step(1'b1, 8'h01,  8'hFF, 1'b0, 1'b0);
        read_check(16'h0C33, "R8 sparse digits");
        step(1'b1, 8'h7F,  8'h00, 1'b0, 1'b0);
        read_check(16'h0C33, "R8 all-zero digits");
    endtask

    task automatic t_idle;
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'd9, 8'd11, 1'b0, 1'b0);
        for (int k = 0; k < 5; k++) step(1'b0, 8'(k * 37 + 5), 8'hA5, 1'b0, 1'b0);
        read_check(16'd99, "R3 idle hold");
    endtask

    task automatic t_clear;
        step(1'b1, 8'd10, 8'd10, 1'b0, 1'b0);
        step(1'b1, 8'd50, 8'd50, 1'b1, 1'b0);
        read_check(16'h0000, "R4 clear beats op");
        step(1'b1, 8'd3, 8'd4, 1'b0, 1'b0);
        step(1'b0, 8'd0, 8'd0, 1'b1, 1'b1);
        step(1'b0, 8'd0, 8'd0, 1'b0, 1'b0);
        check(res_data === 16'd12, "R5 read with clear", res_data, 16'd12);
        read_check(16'h0000, "R4 after clear");
    endtask

    task automatic t_read_same;
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'd6, 8'd7, 1'b0, 1'b0);
        step(1'b1, 8'hFE, 8'd5, 1'b0, 1'b1);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
        check(res_valid === 1'b1, "R5 valid", {15'd0, res_valid}, 16'd1);
        check(res_data === 16'd42, "R5 pre-update value", res_data, 16'd42);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
        check(res_valid === 1'b0, "R5 single pulse", {15'd0, res_valid}, 16'd0);
        read_check(16'd32, "R5 later read");
    endtask

    task automatic t_wrap;
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 8'h80, 8'h80, 1'b0, 1'b0);
        read_check(16'h0000, "R6 wrap to zero");
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        for (int k = 0; k < 300; k++) step(1'b1, 8'h7F, 8'h7F, 1'b0, 1'b0);
        read_check(16'((300 * 16129) % 65536), "R6 long run");
    endtask

    task automatic t_sweep;
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) step(1'b1, 8'(ia), 8'(ib), 1'b0, 1'b0);
            read_check(model, "R2 sweep");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_corners;
        t_zero_digits;
        t_idle;
        t_clear;
        t_read_same;
        t_wrap;
        t_sweep;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule